// File: doc/BRIEF.md
# Exception Entry State Unit

This block computes the architectural state update that a simple 32-bit RISC core makes when it takes an exception. The pipeline presents a one-cycle request with several inputs: a 5-bit cause code, the current, next and pending branch-target program counters, a flag saying the faulting instruction sits in a branch delay slot, and the live status word. One cycle later the block presents a registered result for exactly one cycle:

- the address to resume at,
- a copy of the old status word,
- the modified status word,
- the handler vector,
- pulses that request a full translation-buffer flush, a fall-back to identity address mapping, clearing of the delay-slot flag, and clearing of the pending cause.

The saved resume address depends on two things. Interrupt-like causes (tick timer, external interrupt, system call, floating-point trap) resume after the faulting point: at the branch target inside a delay slot, or at the next PC outside one. All other causes re-execute: the branch (current PC minus 4) inside a delay slot, or the current PC outside one.

A cause code of zero, or a code not below the implemented cause count, is illegal. It produces no entry pulse and leaves every saved output at its old value. It raises a sticky error flag that only reset clears.

Top module: `exc_entry_unit`

## Requirements
- R1: A legal request with ds_i=1 and an interrupt-like cause (codes 5, 8, 12, 13) gives epcr_o equal to jmp_pc_i, one cycle after acceptance.
- R2: A legal request with ds_i=1 and any other legal cause gives epcr_o equal to pc_i minus 4.
- R3: With ds_i=0, interrupt-like causes give epcr_o equal to npc_i, and all other legal causes give epcr_o equal to pc_i.
- R4: esr_o equals the sr_i value sampled with the request, unmodified.
- R5: sr_o equals sr_i with the following changes: bit 0 (supervisor) is set; bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable) and 6 (instruction MMU enable) are cleared; every other bit passes through.
- R6: Bit 13 of sr_o (delay-slot exception) is set when ds_i=1 and passes through from sr_i otherwise. ds_clear_o pulses together with ent_valid_o only when ds_i=1.
- R7: vector_o equals the cause code shifted left by 8 and zero-extended to 32 bits.
- R8: Every legal entry raises ent_valid_o, tlb_flush_o and xlat_ident_o for exactly one cycle, one cycle after the request.
- R9: A cause of 0, or a cause of at least NUM_CAUSES (default 15), gives no ent_valid_o, no flush pulse and no change to epcr_o, esr_o, sr_o or vector_o. It sets cause_err_o from the next cycle on, and cause_err_o stays set until reset.
- R10: While reset is active, all outputs are zero.
- R11: Requests on consecutive cycles each produce their own one-cycle result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Exception request, one cycle per entry |
| cause_i | input | 5 | Exception cause code |
| pc_i | input | 32 | PC of the faulting instruction |
| npc_i | input | 32 | PC of the next sequential instruction |
| jmp_pc_i | input | 32 | Pending branch target |
| ds_i | input | 1 | Faulting instruction is in a delay slot |
| sr_i | input | 32 | Current status word |
| ent_valid_o | output | 1 | Entry result valid; pending cause may be cleared |
| epcr_o | output | 32 | Saved resume address |
| esr_o | output | 32 | Saved status word |
| sr_o | output | 32 | New status word |
| vector_o | output | 32 | Handler address |
| tlb_flush_o | output | 1 | Full translation-buffer flush request |
| xlat_ident_o | output | 1 | Switch code and data mapping to identity |
| ds_clear_o | output | 1 | Clear the delay-slot flag |
| cause_err_o | output | 1 | Sticky illegal-cause flag |

## Verification
The bench runs all four combinations of delay-slot state and cause class. A design that swapped the class test or the delay-slot test would save the wrong one of the three PCs, or forget the minus 4 on the branch. Status words of all ones, all zeros and alternating patterns expose a mask that clears or sets a neighbouring bit, or that drops the delay-slot bit. Codes 0, 15 and 31 check the illegal range at both ends. There the bench watches for a stray entry pulse, a moved vector, and an error flag that drops before reset. Back-to-back requests catch results that merge or stretch across cycles.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN       = 32;
  localparam int CAUSE_W    = 5;
  localparam int NUM_CAUSES = 15;
  localparam int VEC_SHIFT  = 8;

  // status bit positions
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_DSX = 13;

  // interrupt-like causes: tick 5, ext irq 8, syscall 12, fp trap 13
  localparam logic [31:0] RESUME_MASK = 32'h0000_3120;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode #(
  parameter int          CAUSE_W     = exc_entry_pkg::CAUSE_W,
  parameter int          NUM_CAUSES  = exc_entry_pkg::NUM_CAUSES,
  parameter logic [31:0] RESUME_MASK = exc_entry_pkg::RESUME_MASK
) (
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               legal_o,
  output logic               resume_o
);
  localparam int NCODES = 1 << CAUSE_W;
  localparam logic [CAUSE_W:0] NC = NUM_CAUSES[CAUSE_W:0];

  logic [NCODES-1:0] resume_tab;

  for (genvar g = 0; g < NCODES; g++) begin : g_tab
    if (g < 32) begin : g_in
      assign resume_tab[g] = RESUME_MASK[g] && (g < NUM_CAUSES) && (g != 0);
    end else begin : g_out
      assign resume_tab[g] = 1'b0;
    end
  end

  assign legal_o  = (cause_i != '0) && ({1'b0, cause_i} < NC);
  assign resume_o = resume_tab[cause_i];
endmodule

// File: rtl/exc_epc_select.sv
module exc_epc_select #(
  parameter int XLEN = exc_entry_pkg::XLEN
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [XLEN-1:0] jmp_pc_i,
  input  logic            ds_i,
  input  logic            resume_i,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  always_comb begin
    unique case ({ds_i, resume_i})
      2'b11:   epc_o = jmp_pc_i;          // resume at branch target
      2'b10:   epc_o = pc_i - INSN_BYTES; // re-run the branch
      2'b01:   epc_o = npc_i;
      default: epc_o = pc_i;
    endcase
  end
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update #(
  parameter int XLEN   = exc_entry_pkg::XLEN,
  parameter int SR_SM  = exc_entry_pkg::SR_SM,
  parameter int SR_TEE = exc_entry_pkg::SR_TEE,
  parameter int SR_IEE = exc_entry_pkg::SR_IEE,
  parameter int SR_DME = exc_entry_pkg::SR_DME,
  parameter int SR_IME = exc_entry_pkg::SR_IME,
  parameter int SR_DSX = exc_entry_pkg::SR_DSX
) (
  input  logic [XLEN-1:0] sr_i,
  input  logic            ds_i,
  output logic [XLEN-1:0] sr_o
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (b == SR_SM) begin : g_set
      assign sr_o[b] = 1'b1;
    end else if (b == SR_TEE || b == SR_IEE || b == SR_DME || b == SR_IME) begin : g_clr
      assign sr_o[b] = 1'b0;
    end else if (b == SR_DSX) begin : g_dsx
      assign sr_o[b] = sr_i[b] | ds_i;
    end else begin : g_pass
      assign sr_o[b] = sr_i[b];
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int          XLEN        = exc_entry_pkg::XLEN,
  parameter int          CAUSE_W     = exc_entry_pkg::CAUSE_W,
  parameter int          NUM_CAUSES  = exc_entry_pkg::NUM_CAUSES,
  parameter int          VEC_SHIFT   = exc_entry_pkg::VEC_SHIFT,
  parameter logic [31:0] RESUME_MASK = exc_entry_pkg::RESUME_MASK
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    npc_i,
  input  logic [XLEN-1:0]    jmp_pc_i,
  input  logic               ds_i,
  input  logic [XLEN-1:0]    sr_i,
  output logic               ent_valid_o,
  output logic [XLEN-1:0]    epcr_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    sr_o,
  output logic [XLEN-1:0]    vector_o,
  output logic               tlb_flush_o,
  output logic               xlat_ident_o,
  output logic               ds_clear_o,
  output logic               cause_err_o
);
  localparam int VEC_PAD = XLEN - CAUSE_W - VEC_SHIFT;

  logic            legal, resume, take, bad;
  logic [XLEN-1:0] epc_d, sr_d, vec_d;

  exc_cause_decode #(
    .CAUSE_W(CAUSE_W), .NUM_CAUSES(NUM_CAUSES), .RESUME_MASK(RESUME_MASK)
  ) u_dec (
    .cause_i (cause_i),
    .legal_o (legal),
    .resume_o(resume)
  );

  exc_epc_select #(.XLEN(XLEN)) u_epc (
    .pc_i    (pc_i),
    .npc_i   (npc_i),
    .jmp_pc_i(jmp_pc_i),
    .ds_i    (ds_i),
    .resume_i(resume),
    .epc_o   (epc_d)
  );

  exc_sr_update #(.XLEN(XLEN)) u_sr (
    .sr_i(sr_i),
    .ds_i(ds_i),
    .sr_o(sr_d)
  );

  assign vec_d = {{VEC_PAD{1'b0}}, cause_i, {VEC_SHIFT{1'b0}}};
  assign take  = req_valid_i & legal;
  assign bad   = req_valid_i & ~legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_valid_o  <= 1'b0;
      tlb_flush_o  <= 1'b0;
      xlat_ident_o <= 1'b0;
      ds_clear_o   <= 1'b0;
    end else begin
      ent_valid_o  <= take;
      tlb_flush_o  <= take;
      xlat_ident_o <= take;
      ds_clear_o   <= take & ds_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epcr_o   <= '0;
      esr_o    <= '0;
      sr_o     <= '0;
      vector_o <= '0;
    end else if (take) begin
      epcr_o   <= epc_d;
      esr_o    <= sr_i;
      sr_o     <= sr_d;
      vector_o <= vec_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cause_err_o <= 1'b0;
    else if (bad) cause_err_o <= 1'b1;
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int          XLEN        = 32,
  parameter int          CAUSE_W     = 5,
  parameter int          NUM_CAUSES  = 15,
  parameter int          VEC_SHIFT   = 8,
  parameter logic [31:0] RESUME_MASK = 32'h0000_3120
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic [XLEN-1:0]    pc_i,
  input logic [XLEN-1:0]    npc_i,
  input logic [XLEN-1:0]    jmp_pc_i,
  input logic               ds_i,
  input logic [XLEN-1:0]    sr_i,
  input logic               ent_valid_o,
  input logic [XLEN-1:0]    epcr_o,
  input logic [XLEN-1:0]    esr_o,
  input logic [XLEN-1:0]    sr_o,
  input logic [XLEN-1:0]    vector_o,
  input logic               tlb_flush_o,
  input logic               xlat_ident_o,
  input logic               ds_clear_o,
  input logic               cause_err_o
);
  localparam int VEC_PAD = XLEN - CAUSE_W - VEC_SHIFT;

  logic ok, intr;
  assign ok   = (int'(cause_i) != 0) && (int'(cause_i) < NUM_CAUSES);
  assign intr = (int'(cause_i) < 32) ? RESUME_MASK[cause_i] : 1'b0;

  a_r1_ds_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ok && ds_i && intr) |=> (epcr_o == $past(jmp_pc_i)));

  a_r2_ds_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ok && ds_i && !intr) |=> (epcr_o == $past(pc_i) - XLEN'(4)));

  a_r3_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ok && !ds_i) |=> (epcr_o == (intr_q ? npc_q : pc_q)));

  logic            intr_q;
  logic [XLEN-1:0] npc_q, pc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intr_q <= 1'b0; npc_q <= '0; pc_q <= '0;
    end else begin
      intr_q <= intr; npc_q <= npc_i; pc_q <= pc_i;
    end
  end

  a_r4_esr_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ok) |=> (esr_o == $past(sr_i)));

  a_r5_sr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o |-> (sr_o[0] && !sr_o[1] && !sr_o[2] && !sr_o[5] && !sr_o[6]));

  a_r6_ds_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_clear_o |-> (ent_valid_o && sr_o[13]));

  a_r7_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ok) |=> (vector_o == {{VEC_PAD{1'b0}}, $past(cause_i), {VEC_SHIFT{1'b0}}}));

  a_r8_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o |-> (tlb_flush_o && xlat_ident_o));

  a_r9_no_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ok) |=> (!ent_valid_o && cause_err_o && $stable(vector_o)));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_err_o |=> cause_err_o);
endmodule

bind exc_entry_unit exc_entry_checker #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .NUM_CAUSES(NUM_CAUSES),
  .VEC_SHIFT(VEC_SHIFT), .RESUME_MASK(RESUME_MASK)
) u_chk (.*);

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  cause = '0;
  logic [31:0] pc = '0, npc = '0, jmp_pc = '0, sr = '0;
  logic        ds = 1'b0;
  logic        ent_valid, tlb_flush, xlat_ident, ds_clear, cause_err;
  logic [31:0] epcr, esr, sr_new, vector;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  exc_entry_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .cause_i(cause),
    .pc_i(pc), .npc_i(npc), .jmp_pc_i(jmp_pc), .ds_i(ds), .sr_i(sr),
    .ent_valid_o(ent_valid), .epcr_o(epcr), .esr_o(esr), .sr_o(sr_new),
    .vector_o(vector), .tlb_flush_o(tlb_flush), .xlat_ident_o(xlat_ident),
    .ds_clear_o(ds_clear), .cause_err_o(cause_err)
  );

  typedef struct {
    logic        v;
    logic        ds;
    logic [31:0] epc, esr, sr, vec;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic is_intr(input logic [4:0] c);
    return (c == 5'd5) || (c == 5'd8) || (c == 5'd12) || (c == 5'd13);
  endfunction

  task automatic req(input logic [4:0] c, input logic d, input logic [31:0] p,
                     input logic [31:0] s, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; cause = c; ds = d; sr = s;
    pc = p; npc = p + 32'd4; jmp_pc = p ^ 32'h0040_0000;
    e.v   = (c != 0) && (c < 15);
    e.ds  = d;
    e.tag = tag;
    if (d) e.epc = is_intr(c) ? jmp_pc : p - 32'd4;
    else   e.epc = is_intr(c) ? npc : p;
    e.esr = s;
    e.sr  = (s & ~32'h0000_0066) | 32'h1 | (d ? 32'h2000 : 32'h0);
    e.vec = {19'd0, c, 8'd0};
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    if (n > 1) repeat (n - 1) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (sb.size() > 0) begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " R8 valid"}, {31'd0, ent_valid}, {31'd0, e.v});
          if (e.v) begin
            chk({e.tag, " epcr"}, epcr, e.epc);
            chk({e.tag, " R4 esr"}, esr, e.esr);
            chk({e.tag, " R5/R6 sr"}, sr_new, e.sr);
            chk({e.tag, " R7 vector"}, vector, e.vec);
            chk({e.tag, " R8 flush"}, {30'd0, tlb_flush, xlat_ident}, 32'd3);
            chk({e.tag, " R6 ds_clear"}, {31'd0, ds_clear}, {31'd0, e.ds});
          end else begin
            chk({e.tag, " R9 no flush"}, {31'd0, tlb_flush}, 32'd0);
          end
        end else begin
          chk("R8 idle pulse", {29'd0, ent_valid, tlb_flush, xlat_ident}, 32'd0);
        end
      end
    end
  end

  task automatic run();
    logic [31:0] vec_hold, epc_hold;
    #1;
    chk("R10 reset valid", {28'd0, ent_valid, tlb_flush, xlat_ident, cause_err}, 32'd0);
    chk("R10 reset epcr", epcr, 32'd0);
    chk("R10 reset sr", sr_new, 32'd0);
    chk("R10 reset vector", vector, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    req(5'd8,  1'b0, 32'h0000_1000, 32'hFFFF_FFFF, "R3 irq nods");
    idle(2);
    req(5'd2,  1'b0, 32'h0000_2000, 32'h0000_0000, "R3 fault nods");
    idle(2);
    req(5'd5,  1'b1, 32'h0000_3004, 32'hA5A5_5A5A, "R1 tick ds");
    idle(2);
    req(5'd3,  1'b1, 32'h0000_4008, 32'h5A5A_A5A5, "R2 fault ds");
    idle(2);
    req(5'd12, 1'b1, 32'h0000_5010, 32'h0000_2000, "R1 syscall ds");
    idle(1);
    req(5'd13, 1'b0, 32'h0000_6000, 32'hFFFF_DF99, "R3 fpe nods");
    idle(1);
    req(5'd14, 1'b0, 32'h0000_7000, 32'h1234_5678, "R7 max cause");
    idle(1);
    req(5'd1,  1'b1, 32'h0000_8000, 32'h8000_0001, "R2 min cause");
    idle(2);

    // back-to-back
    req(5'd4,  1'b0, 32'h0001_0000, 32'h0000_0F0F, "R11 b2b a");
    req(5'd8,  1'b1, 32'h0002_0000, 32'hF0F0_0000, "R11 b2b b");
    req(5'd9,  1'b1, 32'h0003_0000, 32'h0000_00FF, "R11 b2b c");
    idle(2);
    chk("R9 err before illegal", {31'd0, cause_err}, 32'd0);

    vec_hold = vector; epc_hold = epcr;
    req(5'd0, 1'b0, 32'h0009_0000, 32'hFFFF_FFFF, "R9 cause0");
    idle(1);
    chk("R9 err set", {31'd0, cause_err}, 32'd1);
    chk("R9 vector held", vector, vec_hold);
    chk("R9 epcr held", epcr, epc_hold);
    req(5'd15, 1'b1, 32'h0009_1000, 32'h0, "R9 cause15");
    req(5'd31, 1'b0, 32'h0009_2000, 32'h0, "R9 cause31");
    idle(2);
    chk("R9 vector held 2", vector, vec_hold);
    req(5'd6, 1'b0, 32'h000A_0000, 32'h0000_0040, "R9 legal after err");
    idle(3);
    chk("R9 err sticky", {31'd0, cause_err}, 32'd1);

    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R10 reset clears err", {31'd0, cause_err}, 32'd0);
    chk("R10 reset clears esr", esr, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R10 sb drained", sb.size(), 32'd0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule